// File: doc/BRIEF.md
# Register-Mapped Serial Port with Programmable Bit Period

This block is a one-byte-deep asynchronous serial port that a processor reaches through two 32-bit registers. Word 0 holds the bit period, given as a count of system clocks. Word 1 is the data port. A write to word 1 sends a byte on the transmit pin. A read of word 1 returns the byte that was received last. The frame format is fixed: one low start bit, eight data bits least significant first, and one high stop bit. There is no parity and no flow control. The transmit and receive lines connect straight to the pins.

The bus side uses a valid/ready handshake. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` drops only when a write to the data port arrives while a frame is still on the line. The requester must then hold the request steady until ready returns. Every other access completes in the cycle it is presented. Read data is combinational and must be taken in the accepting cycle.

The receiver keeps a single holding byte and a flag that marks it as full. A read empties the holding byte. A new byte that arrives before the read replaces the old one.

Top module: `uart_mm`

## Requirements
- R1: After reset the bit-period register reads 1, a data-port read returns 0xFFFFFFFF, and `uart_txd` is high.
- R2: A write to word 0 (`req_sel`=0) stores all 32 bits, and a read of word 0 returns the same 32-bit value.
- R3: A write to word 1 (`req_sel`=1) sends one frame on `uart_txd`, made of a low start bit, `req_wdata[7:0]` least significant bit first, and a high stop bit. Each bit lasts as many clocks as the bit-period value, and a value of 0 counts as 1.
- R4: A data-port write that arrives while a frame is being sent sees `req_ready` low. It is accepted on the edge that comes one clock after the previous stop bit ends, so two back-to-back writes are accepted 10×period+1 clocks apart.
- R5: Reads of either word, and writes to word 0, complete with `req_ready` high in the cycle they are presented, even while a frame is being sent.
- R6: The receiver waits for a falling edge on `uart_rxd` and samples each bit near its middle. Once a valid stop bit is seen, a data-port read returns the received byte zero-extended to 32 bits.
- R7: A data-port read empties the holding byte, so the next read returns 0xFFFFFFFF unless another byte has arrived in the meantime.
- R8: A byte that arrives while the holding byte is still full replaces the older byte.
- R9: A data-port read with an empty holding byte returns 0xFFFFFFFF.
- R10: The bit period is captured when a frame starts. Writing word 0 during a frame does not change the timing of that frame.
- R11: A frame whose stop bit samples low is thrown away. The holding byte stays as it was, and the receiver picks up the next frame correctly.
- R12: A low pulse on `uart_rxd` that has ended by the time the start bit is sampled at half a bit period is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | Register select: 0 = bit period, 1 = data port |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the accepting cycle |
| uart_txd | output | 1 | Serial transmit pin, idle high |
| uart_rxd | input | 1 | Serial receive pin, idle high |

## Verification
If a bit counter or period counter in the transmitter is wrong, the result is a frame of the wrong length or a wrong bit on `uart_txd` within one bit period. A line monitor that samples at mid-bit catches it, and so does the accept spacing of back-to-back writes. If the holding byte or its full flag is wrong, the very next data-port read shows it, because that read returns either a stale byte or all ones where the other is expected. Receiver state errors show up at the end of the frame as a lost, wrong or extra byte. Tests with a bad stop bit and with a short glitch expose them within a single frame.

// File: rtl/uart_mm_pkg.sv
`timescale 1ns/1ps
package uart_mm_pkg;
  localparam logic SEL_PERIOD = 1'b0;
  localparam logic SEL_DATA   = 1'b1;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/ser_tx.sv
`timescale 1ns/1ps
module ser_tx #(
  parameter int DATA_BITS = 8,
  parameter int CNT_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic [CNT_W-1:0]     period_i,
  output logic                 busy_o,
  output logic                 txd_o
);
  localparam int BIT_W = $clog2(DATA_BITS + 2);

  logic                 busy_q, txd_q;
  logic [CNT_W-1:0]     per_q, cnt_q, eff_m1;
  logic [DATA_BITS:0]   sh_q;
  logic [BIT_W-1:0]     left_q;

  // a period of 0 behaves like a period of 1
  always_comb eff_m1 = (period_i == '0) ? '0 : period_i - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      per_q  <= '0;
      cnt_q  <= '0;
      sh_q   <= '1;
      left_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        txd_q  <= 1'b0;
        sh_q   <= {1'b1, data_i};
        left_q <= BIT_W'(DATA_BITS + 1);
        per_q  <= eff_m1;
        cnt_q  <= eff_m1;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (left_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      txd_q  <= sh_q[0];
      sh_q   <= {1'b1, sh_q[DATA_BITS:1]};
      left_q <= left_q - BIT_W'(1);
      cnt_q  <= per_q;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = txd_q;

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd_q); // R3
  AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_q); // R3
  AST_TX_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start_i); // R4
endmodule

// File: rtl/ser_rx.sv
`timescale 1ns/1ps
module ser_rx
  import uart_mm_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int CNT_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd_i,
  input  logic [CNT_W-1:0]     period_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] data_o
);
  localparam int LEFT_W = $clog2(DATA_BITS + 1);

  rx_state_t            state_q;
  logic                 s1_q, s2_q, s3_q, fall;
  logic [CNT_W-1:0]     per_q, cnt_q, eff, eff_m1;
  logic [DATA_BITS-1:0] sh_q, data_q;
  logic [LEFT_W-1:0]    left_q;
  logic                 done_q;

  always_comb begin
    eff    = (period_i == '0) ? CNT_W'(1) : period_i;
    eff_m1 = eff - CNT_W'(1);
    fall   = s3_q & ~s2_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= rxd_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      per_q   <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        RX_IDLE: if (fall) begin
          state_q <= RX_START;
          per_q   <= eff_m1;
          cnt_q   <= eff >> 1;
        end
        RX_START: if (cnt_q != '0) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end else if (!s2_q) begin
          state_q <= RX_DATA;
          cnt_q   <= per_q;
          left_q  <= LEFT_W'(DATA_BITS);
        end else begin
          state_q <= RX_IDLE;
        end
        RX_DATA: if (cnt_q != '0) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end else begin
          sh_q   <= {s2_q, sh_q[DATA_BITS-1:1]};
          cnt_q  <= per_q;
          left_q <= left_q - LEFT_W'(1);
          if (left_q == LEFT_W'(1)) state_q <= RX_STOP;
        end
        RX_STOP: if (cnt_q != '0) begin
          cnt_q <= cnt_q - CNT_W'(1);
        end else begin
          state_q <= RX_IDLE;
          if (s2_q) begin
            done_q <= 1'b1;
            data_q <= sh_q;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;

  AST_RX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(s2_q)); // R11
  AST_RX_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(state_q == RX_STOP)); // R6
  AST_RX_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START) && $past(state_q == RX_IDLE) |-> $past(fall)); // R12
endmodule

// File: rtl/uart_mm.sv
`timescale 1ns/1ps
module uart_mm
  import uart_mm_pkg::*;
#(
  parameter int          DATA_BITS = 8,
  parameter int          BUS_W     = 32,
  parameter int          DIV_W     = 32,
  parameter logic [31:0] DIV_RESET = 32'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_sel,
  input  logic [BUS_W-1:0] req_wdata,
  output logic [BUS_W-1:0] rsp_rdata,
  output logic             uart_txd,
  input  logic             uart_rxd
);
  logic [DIV_W-1:0]     div_q;
  logic [DATA_BITS-1:0] hold_q, rx_data;
  logic                 hold_vld, rx_done, tx_busy;
  logic                 acc, wr_div, wr_dat, rd_dat;

  always_comb begin
    req_ready = !(req_valid && req_write && (req_sel == SEL_DATA) && tx_busy);
    acc       = req_valid && req_ready;
    wr_div    = acc && req_write && (req_sel == SEL_PERIOD);
    wr_dat    = acc && req_write && (req_sel == SEL_DATA);
    rd_dat    = acc && !req_write && (req_sel == SEL_DATA);
    if (req_sel == SEL_PERIOD)
      rsp_rdata = BUS_W'(div_q);
    else if (hold_vld)
      rsp_rdata = BUS_W'(hold_q);
    else
      rsp_rdata = '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= DIV_W'(DIV_RESET);
      hold_q   <= '0;
      hold_vld <= 1'b0;
    end else begin
      if (wr_div) div_q <= req_wdata[DIV_W-1:0];
      if (rx_done) begin
        hold_q   <= rx_data;
        hold_vld <= 1'b1;
      end else if (rd_dat) begin
        hold_vld <= 1'b0;
      end
    end
  end

  ser_tx #(.DATA_BITS(DATA_BITS), .CNT_W(DIV_W)) tx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (wr_dat),
    .data_i   (req_wdata[DATA_BITS-1:0]),
    .period_i (div_q),
    .busy_o   (tx_busy),
    .txd_o    (uart_txd)
  );

  ser_rx #(.DATA_BITS(DATA_BITS), .CNT_W(DIV_W)) rx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxd_i    (uart_rxd),
    .period_i (div_q),
    .done_o   (rx_done),
    .data_o   (rx_data)
  );

  AST_TX_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> tx_busy); // R3
  AST_DIV_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> $past(wr_div)); // R2
  AST_HOLD_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_vld) |-> $past(rd_dat)); // R7
  AST_HOLD_FILL_BY_RX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_vld) |-> $past(rx_done)); // R6
endmodule

// File: tb/uart_mm_tb_top.sv
`timescale 1ns/1ps
module uart_mm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_sel = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        uart_txd;
  logic        uart_rxd = 1'b1;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [39:0] exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_mm dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .uart_txd(uart_txd), .uart_rxd(uart_rxd)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input bit wr, input bit sel, input logic [31:0] wd,
                        output logic [31:0] rd, output int stall, output int at);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel = sel; req_wdata = wd;
    stall = 0;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1; stall++;
    end
    rd = rsp_rdata;
    at = cyc;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic rd_data(input string req, input logic [31:0] exp);
    logic [31:0] rd; int st; int at;
    bus_op(1'b0, 1'b1, '0, rd, st, at);
    check(rd === exp, req, rd, exp);
  endtask

  task automatic send(input logic [7:0] b, input int d, output int st, output int at);
    logic [31:0] rd;
    exp_q.push_back({d[31:0], b});
    bus_op(1'b1, 1'b1, {24'h0, b}, rd, st, at);
  endtask

  task automatic rx_frame(input logic [7:0] b, input int d, input bit stop);
    @(negedge clk);
    uart_rxd = 1'b0;
    repeat (d) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      uart_rxd = b[i];
      repeat (d) @(negedge clk);
    end
    uart_rxd = stop;
    repeat (d) @(negedge clk);
    uart_rxd = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // line monitor: pops the expected frame and compares it at mid-bit
  initial begin
    logic [39:0] item;
    logic [7:0]  got;
    int          d;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (uart_txd === 1'b0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected frame", 32'h0, 32'h1);
          item = {32'd8, 8'h00};
        end else begin
          item = exp_q.pop_front();
        end
        d = int'(item[39:8]);
        repeat (d / 2) @(negedge clk);
        check(uart_txd === 1'b0, "R3 start bit", {31'h0, uart_txd}, 32'h0);
        for (int i = 0; i < 8; i++) begin
          repeat (d) @(negedge clk);
          got[i] = uart_txd;
        end
        check(got === item[7:0], "R3/R10 frame data", {24'h0, got}, {24'h0, item[7:0]});
        repeat (d) @(negedge clk);
        check(uart_txd === 1'b1, "R3 stop bit", {31'h0, uart_txd}, 32'h1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int st, at, at0, st1;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    #1 check(uart_txd === 1'b1, "R1 txd idle", {31'h0, uart_txd}, 32'h1);
    bus_op(1'b0, 1'b0, '0, rd, st, at);
    check(rd === 32'd1, "R1 period reset", rd, 32'd1);
    check(st == 0, "R5 period read stall", st, 0);
    rd_data("R1/R9 empty read", 32'hFFFF_FFFF);

    // R2 full-width readback
    bus_op(1'b1, 1'b0, 32'hDEAD_BEEF, rd, st, at);
    bus_op(1'b0, 1'b0, '0, rd, st, at);
    check(rd === 32'hDEAD_BEEF, "R2 period readback", rd, 32'hDEAD_BEEF);
    bus_op(1'b1, 1'b0, 32'd8, rd, st, at);
    bus_op(1'b0, 1'b0, '0, rd, st, at);
    check(rd === 32'd8, "R2 period readback 8", rd, 32'd8);

    // R3 and R4: two back-to-back frames
    send(8'hA5, 8, st, at0);
    check(st == 0, "R4 idle write no stall", st, 0);
    send(8'h01, 8, st1, at);
    check(st1 > 0, "R4 busy write stalled", st1, 1);
    check(at - at0 == 81, "R4 accept spacing", at - at0, 81);
    // R5 read during transmit completes at once
    bus_op(1'b0, 1'b0, '0, rd, st, at);
    check(st == 0, "R5 read while busy", st, 0);
    repeat (120) @(negedge clk);

    // R10 period change mid-frame
    send(8'h3C, 8, st, at);
    bus_op(1'b1, 1'b0, 32'd12, rd, st, at);
    check(st == 0, "R5 period write while busy", st, 0);
    send(8'hC3, 12, st, at);
    repeat (160) @(negedge clk);

    // R6 receive and R7 clear
    rx_frame(8'h5A, 12, 1'b1);
    rd_data("R6 received byte", 32'h0000_005A);
    rd_data("R7 cleared after read", 32'hFFFF_FFFF);

    // R8 overwrite
    rx_frame(8'h11, 12, 1'b1);
    rx_frame(8'h22, 12, 1'b1);
    rd_data("R8 newest byte kept", 32'h0000_0022);
    rd_data("R9 empty again", 32'hFFFF_FFFF);

    // R11 bad stop bit dropped, then recovery
    rx_frame(8'h77, 12, 1'b0);
    repeat (30) @(negedge clk);
    rd_data("R11 framing error dropped", 32'hFFFF_FFFF);
    rx_frame(8'h99, 12, 1'b1);
    rd_data("R11 recovery byte", 32'h0000_0099);

    // R12 short glitch ignored
    @(negedge clk); uart_rxd = 1'b0;
    repeat (2) @(negedge clk); uart_rxd = 1'b1;
    repeat (200) @(negedge clk);
    rd_data("R12 glitch ignored", 32'hFFFF_FFFF);
    rx_frame(8'h6E, 12, 1'b1);
    rd_data("R12 byte after glitch", 32'h0000_006E);

    check(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule